// File: doc/BRIEF.md
# Speculative Fragment Burst Checker

A receive path that writes IP fragments straight into a zero-copy page has to guess where each payload belongs. The guess is made before any header is examined. This block checks the guess afterwards. For every fragment the receive engine hands over one header strobe carrying five values:

- the protocol number,
- the IP identification,
- the fragment offset,
- the more-fragments flag,
- the payload length.

The checker compares these against the single datagram layout that a page-sized transfer must have. It does not judge each packet on its own merit.

The block raises one coalesced interrupt per burst. That happens when the expected number of fragments has arrived, or earlier if a timeout runs out. The interrupt carries a pass or fail indication. On any failure the block raises a stop request for the receive DMA and ignores all further fragments. It stays that way until software issues a single restart write. Copying misplaced data out of the page is left to software.

The controller is a five-state machine:

- IDLE waits for the first fragment of a burst.
- COLLECT holds while the later fragments arrive. It tracks the captured identification, the next expected offset and a timeout counter.
- REPORT_OK is a one-cycle success report. It behaves like IDLE towards a fragment arriving in that cycle.
- REPORT_BAD is a one-cycle failure report.
- HALTED holds the stop request.

The transitions are:

- IDLE or REPORT_OK to COLLECT on a good non-final fragment.
- IDLE, REPORT_OK or COLLECT to REPORT_OK on a good final fragment.
- IDLE, REPORT_OK or COLLECT to REPORT_BAD on a bad fragment.
- COLLECT to REPORT_BAD when the timeout expires.
- REPORT_OK to IDLE with no fragment.
- REPORT_BAD to HALTED.
- REPORT_BAD or HALTED to IDLE on a restart write.

Top module: `frag_burst_checker`

## Requirements
- R1: While and after reset, with no stimulus, irq, burst_pass and dma_stop are all 0.
- R2: A burst passes when all of the following hold, with FRAGS=3, protocol 6 and DGRAM_BYTES=4116:
  - it has FRAGS fragments, each with protocol EXP_PROTO;
  - every fragment has the identification of the first one;
  - the first offset is 0, and each later offset (in 8-byte units) equals the previous offset plus the previous length divided by 8;
  - the more-fragments flag is 1 on all fragments but the last and 0 on the last;
  - every non-final length is a nonzero multiple of 8;
  - the final offset*8 plus the final length equals DGRAM_BYTES.
  On a passing burst irq and burst_pass are 1 for exactly the one cycle after the final strobe's clock edge, and dma_stop stays 0.
- R3: A fragment whose identification differs from the first fragment's fails the burst. In the cycle after its edge irq=1 and burst_pass=0, and dma_stop becomes 1 in that same cycle.
- R4: A wrong offset fails the burst as in R3. This covers a nonzero offset on the first fragment and a later offset that breaks the running sum.
- R5: A wrong more-fragments flag fails the burst as in R3. This covers a 0 before the last fragment and a 1 on the last.
- R6: A protocol value other than EXP_PROTO fails the burst as in R3.
- R7: A length fault fails the burst as in R3. This covers a non-final length that is zero or not a multiple of 8, and a final offset*8+length different from DGRAM_BYTES.
- R8: The timeout starts at the clock edge that accepts a burst's first fragment. If the final fragment has not been accepted TIMEOUT_CYC edges later, a failure is reported in the cycle after that edge. A fragment strobe at that edge takes precedence over the timeout.
- R9: After a failure dma_stop stays 1 and fragment strobes cause no irq. A restart_wr pulse returns the block to idle, which clears dma_stop from the next cycle. A new burst is then checked normally.
- R10: restart_wr while no failure is pending has no effect on the outputs or on a following burst.
- R11: A fragment arriving in the cycle of a success report starts the next burst as the first fragment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frag_stb | input | 1 | One-cycle strobe: header fields of one fragment are valid |
| frag_proto | input | 8 | IP protocol number of the fragment |
| frag_id | input | 16 | IP identification |
| frag_off | input | 13 | Fragment offset in 8-byte units |
| frag_mf | input | 1 | More-fragments flag |
| frag_len | input | 16 | IP payload length of the fragment in bytes |
| restart_wr | input | 1 | Restart write that clears an aborted burst |
| irq | output | 1 | Coalesced interrupt, one cycle per burst outcome |
| burst_pass | output | 1 | Qualifies irq: 1 for success, 0 for misspeculation |
| dma_stop | output | 1 | Request to halt receive DMA after a failure |

## Verification
A wrong captured identification or a stale expected offset shows up only at the next strobe. It appears as a failure interrupt where a pass was due, or the reverse, one cycle after that strobe. A wrong timeout count moves the failure interrupt off the edge that is TIMEOUT_CYC edges after the first fragment, or makes it appear during an active burst. A state machine stuck in or out of HALTED shows as dma_stop failing to hold, or failing to fall the cycle after a restart. A cycle-accurate reference model compares all three outputs every clock, so any of these faults is seen in the first cycle it affects.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

    localparam int PROTO_W = 8;
    localparam int ID_W    = 16;
    localparam int OFF_W   = 13;
    localparam int LEN_W   = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_REPORT_OK,
        ST_REPORT_BAD,
        ST_HALTED
    } fbc_state_e;

    typedef struct packed {
        logic [PROTO_W-1:0] proto;
        logic [ID_W-1:0]    id;
        logic [OFF_W-1:0]   off;
        logic               mf;
        logic [LEN_W-1:0]   len;
    } frag_hdr_t;

endpackage

// File: rtl/fbc_field_check.sv
module fbc_field_check
    import fbc_pkg::*;
#(
    parameter int EXP_PROTO   = 6,
    parameter int DGRAM_BYTES = 4116
) (
    input  frag_hdr_t        hdr,
    input  logic             is_first,
    input  logic             is_last,
    input  logic [ID_W-1:0]  exp_id,
    input  logic [OFF_W-1:0] exp_off,
    output logic             hdr_good,
    output logic [OFF_W-1:0] next_off
);
    localparam int END_W = OFF_W + 4;

    logic             proto_ok, id_ok, off_ok, mf_ok, len_ok;
    logic [END_W-1:0] end_byte;

    always_comb begin
        end_byte = {1'b0, hdr.off, 3'b000} + END_W'(hdr.len);
        proto_ok = (hdr.proto == PROTO_W'(EXP_PROTO));
        id_ok    = is_first || (hdr.id == exp_id);
        off_ok   = is_first ? (hdr.off == '0) : (hdr.off == exp_off);
        mf_ok    = (hdr.mf == !is_last);
        if (is_last) begin
            len_ok = (end_byte == END_W'(DGRAM_BYTES));
        end else begin
            len_ok = (hdr.len != '0) && (hdr.len[2:0] == 3'b000);
        end
        hdr_good = proto_ok && id_ok && off_ok && mf_ok && len_ok;
        next_off = hdr.off + hdr.len[LEN_W-1:3];
    end

endmodule

// File: rtl/fbc_timeout.sv
module fbc_timeout #(
    parameter int TIMEOUT_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    logic [TW-1:0] age_q;

    assign expired = (age_q == TW'(TIMEOUT_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (!run) begin
            age_q <= '0;
        end else if (!expired) begin
            age_q <= age_q + 1'b1;
        end
    end

endmodule

// File: rtl/frag_burst_checker.sv
module frag_burst_checker
    import fbc_pkg::*;
#(
    parameter int FRAGS       = 3,
    parameter int EXP_PROTO   = 6,
    parameter int DGRAM_BYTES = 4116,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frag_stb,
    input  logic [7:0]  frag_proto,
    input  logic [15:0] frag_id,
    input  logic [12:0] frag_off,
    input  logic        frag_mf,
    input  logic [15:0] frag_len,
    input  logic        restart_wr,
    output logic        irq,
    output logic        burst_pass,
    output logic        dma_stop
);
    localparam int CW = $clog2(FRAGS + 1);

    fbc_state_e       state_q, state_d;
    logic [CW-1:0]    seen_q;
    logic [ID_W-1:0]  id_q;
    logic [OFF_W-1:0] off_q;

    frag_hdr_t        hdr;
    logic             at_start, is_last, hdr_good, tmo_hit;
    logic [OFF_W-1:0] next_off;

    assign hdr      = '{proto: frag_proto, id: frag_id, off: frag_off,
                        mf: frag_mf, len: frag_len};
    assign at_start = (state_q == ST_IDLE) || (state_q == ST_REPORT_OK);
    assign is_last  = at_start ? (FRAGS == 1) : (seen_q == CW'(FRAGS - 1));

    fbc_field_check #(
        .EXP_PROTO   (EXP_PROTO),
        .DGRAM_BYTES (DGRAM_BYTES)
    ) u_check (
        .hdr      (hdr),
        .is_first (at_start),
        .is_last  (is_last),
        .exp_id   (id_q),
        .exp_off  (off_q),
        .hdr_good (hdr_good),
        .next_off (next_off)
    );

    fbc_timeout #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_timeout (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_COLLECT),
        .expired (tmo_hit)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_REPORT_OK: begin
                if (frag_stb) begin
                    state_d = !hdr_good ? ST_REPORT_BAD :
                              (is_last ? ST_REPORT_OK : ST_COLLECT);
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_COLLECT: begin
                if (frag_stb) begin
                    state_d = !hdr_good ? ST_REPORT_BAD :
                              (is_last ? ST_REPORT_OK : ST_COLLECT);
                end else if (tmo_hit) begin
                    state_d = ST_REPORT_BAD;
                end
            end
            ST_REPORT_BAD, ST_HALTED: begin
                state_d = restart_wr ? ST_IDLE : ST_HALTED;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state and burst context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            seen_q  <= '0;
            id_q    <= '0;
            off_q   <= '0;
        end else begin
            state_q <= state_d;
            if (frag_stb && hdr_good && (at_start || state_q == ST_COLLECT)) begin
                seen_q <= at_start ? CW'(1) : seen_q + 1'b1;
                off_q  <= next_off;
                if (at_start) begin
                    id_q <= frag_id;
                end
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        irq        = (state_q == ST_REPORT_OK) || (state_q == ST_REPORT_BAD);
        burst_pass = (state_q == ST_REPORT_OK);
        dma_stop   = (state_q == ST_REPORT_BAD) || (state_q == ST_HALTED);
    end

endmodule

// File: rtl/fbc_checker.sv
module fbc_checker (
    input logic clk,
    input logic rst_n,
    input logic frag_stb,
    input logic restart_wr,
    input logic irq,
    input logic burst_pass,
    input logic dma_stop
);
    assert_pass_with_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        burst_pass |-> irq);

    assert_pass_follows_frag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && burst_pass) |-> $past(frag_stb));

    assert_pass_no_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && burst_pass) |-> !dma_stop);

    assert_fail_raises_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !burst_pass) |-> dma_stop);

    assert_stop_rises_with_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_stop) |-> (irq && !burst_pass));

    assert_stop_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_stop && !restart_wr) |=> dma_stop);

    assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_stop && restart_wr) |=> !dma_stop);

    assert_quiet_when_halted_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_stop && $past(dma_stop)) |-> !irq);

endmodule

bind frag_burst_checker fbc_checker u_fbc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .frag_stb   (frag_stb),
    .restart_wr (restart_wr),
    .irq        (irq),
    .burst_pass (burst_pass),
    .dma_stop   (dma_stop)
);

// File: tb/frag_burst_checker_test.sv
module frag_burst_checker_test;
    localparam int FRAGS = 3;
    localparam int PROTO = 6;
    localparam int DG    = 4116;
    localparam int TMO   = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frag_stb = 1'b0;
    logic [7:0]  frag_proto = '0;
    logic [15:0] frag_id = '0;
    logic [12:0] frag_off = '0;
    logic        frag_mf = 1'b0;
    logic [15:0] frag_len = '0;
    logic        restart_wr = 1'b0;
    logic        irq, burst_pass, dma_stop;

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    // reference model state
    int m_cnt = 0;
    int m_age = 0;
    int m_id = 0;
    int m_next = 0;
    bit m_halt = 0;
    bit e_irq = 0, e_pass = 0, e_stop = 0;

    always #5 clk = ~clk;

    frag_burst_checker #(
        .FRAGS(FRAGS), .EXP_PROTO(PROTO), .DGRAM_BYTES(DG), .TIMEOUT_CYC(TMO)
    ) uut (
        .clk(clk), .rst_n(rst_n), .frag_stb(frag_stb), .frag_proto(frag_proto),
        .frag_id(frag_id), .frag_off(frag_off), .frag_mf(frag_mf),
        .frag_len(frag_len), .restart_wr(restart_wr), .irq(irq),
        .burst_pass(burst_pass), .dma_stop(dma_stop)
    );

    task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s {irq,pass,stop} actual=%b expected=%b at %0t",
                     req, act, exp, $time);
        end
    endtask

    function automatic bit frag_ok(int idx);
        bit last = (idx == FRAGS - 1);
        int len = int'(frag_len);
        int off = int'(frag_off);
        if (int'(frag_proto) != PROTO) return 0;
        if (idx != 0 && int'(frag_id) != m_id) return 0;
        if (off != ((idx == 0) ? 0 : m_next)) return 0;
        if (frag_mf != !last) return 0;
        if (last) return (off * 8 + len == DG);
        return (len != 0) && (len % 8 == 0);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_age = 0; m_halt = 0;
            e_irq = 0; e_pass = 0;
        end else begin
            e_irq = 0; e_pass = 0;
            if (m_halt) begin
                if (restart_wr) m_halt = 0;
            end else begin
                if (m_cnt > 0) m_age++;
                if (frag_stb) begin
                    if (frag_ok(m_cnt)) begin
                        if (m_cnt == 0) m_id = int'(frag_id);
                        m_next = (int'(frag_off) + int'(frag_len) / 8) % 8192;
                        if (m_cnt == FRAGS - 1) begin
                            e_irq = 1; e_pass = 1; m_cnt = 0;
                        end else begin
                            if (m_cnt == 0) m_age = 0;
                            m_cnt++;
                        end
                    end else begin
                        e_irq = 1; m_halt = 1; m_cnt = 0;
                    end
                end else if (m_cnt > 0 && m_age >= TMO) begin
                    e_irq = 1; m_halt = 1; m_cnt = 0;
                end
            end
        end
        e_stop = m_halt;
        #2;
        if (!finished) chk(cur_req, {irq, burst_pass, dma_stop}, {e_irq, e_pass, e_stop});
    end

    task automatic put(int p, int id, int off, bit mf, int len);
        frag_stb = 1'b1;
        frag_proto = 8'(p); frag_id = 16'(id); frag_off = 13'(off);
        frag_mf = mf; frag_len = 16'(len);
        @(negedge clk);
    endtask

    task automatic gap(int n);
        frag_stb = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic restart();
        restart_wr = 1'b1;
        @(negedge clk);
        restart_wr = 1'b0;
    endtask

    task automatic good_burst(int id);
        put(PROTO, id, 0, 1, 1480);
        put(PROTO, id, 185, 1, 1480);
        put(PROTO, id, 370, 0, 1156);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #200000000;
        failures++;
        $display("FAIL watchdog expired (R1..) actual=hung expected=done");
        finish_run();
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        chk("R1", {irq, burst_pass, dma_stop}, 3'b000);
        rst_n = 1'b1;
        gap(3);
        chk("R1", {irq, burst_pass, dma_stop}, 3'b000);

        cur_req = "R2";
        put(PROTO, 16'h1234, 0, 1, 1480); gap(2);
        put(PROTO, 16'h1234, 185, 1, 1480); gap(4);
        put(PROTO, 16'h1234, 370, 0, 1156);
        chk("R2", {irq, burst_pass, dma_stop}, 3'b110);
        gap(1);
        chk("R2", {irq, burst_pass, dma_stop}, 3'b000);
        gap(2);

        cur_req = "R11";
        good_burst(16'h0042);
        good_burst(16'h0043);
        chk("R11", {irq, burst_pass, dma_stop}, 3'b110);
        gap(3);

        cur_req = "R3";
        put(PROTO, 16'h00A0, 0, 1, 1480);
        put(PROTO, 16'h00A1, 185, 1, 1480);
        chk("R3", {irq, burst_pass, dma_stop}, 3'b101);
        gap(2);

        cur_req = "R9";
        chk("R9", {irq, burst_pass, dma_stop}, 3'b001);
        good_burst(16'h00B0);
        chk("R9", {irq, burst_pass, dma_stop}, 3'b001);
        gap(2);
        restart();
        chk("R9", {irq, burst_pass, dma_stop}, 3'b000);
        good_burst(16'h00B1);
        chk("R9", {irq, burst_pass, dma_stop}, 3'b110);
        gap(2);

        cur_req = "R4";
        put(PROTO, 16'h00C0, 8, 1, 1480);
        chk("R4", {irq, burst_pass, dma_stop}, 3'b101);
        gap(1); restart(); gap(1);
        put(PROTO, 16'h00C1, 0, 1, 1480);
        put(PROTO, 16'h00C1, 186, 1, 1480);
        chk("R4", {irq, burst_pass, dma_stop}, 3'b101);
        gap(1); restart(); gap(1);

        cur_req = "R5";
        put(PROTO, 16'h00D0, 0, 0, 1480);
        chk("R5", {irq, burst_pass, dma_stop}, 3'b101);
        restart(); gap(1);
        put(PROTO, 16'h00D1, 0, 1, 1480);
        put(PROTO, 16'h00D1, 185, 1, 1480);
        put(PROTO, 16'h00D1, 370, 1, 1156);
        chk("R5", {irq, burst_pass, dma_stop}, 3'b101);
        gap(1); restart(); gap(1);

        cur_req = "R6";
        put(PROTO, 16'h00E0, 0, 1, 1480);
        put(17, 16'h00E0, 185, 1, 1480);
        chk("R6", {irq, burst_pass, dma_stop}, 3'b101);
        gap(1); restart(); gap(1);

        cur_req = "R7";
        put(PROTO, 16'h00F0, 0, 1, 1480);
        put(PROTO, 16'h00F0, 185, 1, 1480);
        put(PROTO, 16'h00F0, 370, 0, 1160);
        chk("R7", {irq, burst_pass, dma_stop}, 3'b101);
        gap(1); restart(); gap(1);
        put(PROTO, 16'h00F1, 0, 1, 1484);
        chk("R7", {irq, burst_pass, dma_stop}, 3'b101);
        gap(1); restart(); gap(1);
        put(PROTO, 16'h00F2, 0, 1, 0);
        chk("R7", {irq, burst_pass, dma_stop}, 3'b101);
        gap(1); restart(); gap(1);

        cur_req = "R8";
        put(PROTO, 16'h0100, 0, 1, 1480);
        put(PROTO, 16'h0100, 185, 1, 1480);
        gap(TMO - 2);
        chk("R8", {irq, burst_pass, dma_stop}, 3'b000);
        gap(1);
        chk("R8", {irq, burst_pass, dma_stop}, 3'b101);
        gap(2); restart(); gap(1);
        put(PROTO, 16'h0101, 0, 1, 1480);
        gap(TMO - 2);
        put(PROTO, 16'h0101, 185, 1, 1480);
        chk("R8", {irq, burst_pass, dma_stop}, 3'b000);
        gap(1);
        chk("R8", {irq, burst_pass, dma_stop}, 3'b101);
        gap(1); restart(); gap(1);

        cur_req = "R10";
        restart();
        chk("R10", {irq, burst_pass, dma_stop}, 3'b000);
        put(PROTO, 16'h0110, 0, 1, 1480);
        restart_wr = 1'b1;
        put(PROTO, 16'h0110, 185, 1, 1480);
        restart_wr = 1'b0;
        put(PROTO, 16'h0110, 370, 0, 1156);
        chk("R10", {irq, burst_pass, dma_stop}, 3'b110);
        gap(4);

        finish_run();
    end

endmodule